// File: doc/BRIEF.md
# Scroll-Match Trigger Channel Monitor

This block observes writes to a video control register that carries a 3-bit vertical scroll field and a display-enable bit. It compares the stored scroll field bit by bit against the low three bits of the raster line counter. A write that turns a mismatch into a match is a trigger event. Each event gets a channel: the bitwise XOR of the previously stored scroll value and the raster bits. The channel is therefore always between 1 and 7.

Every event increments one saturating counter in a grid. The grid has one row per raster low-bit value and one column per channel, so it holds 8 x 7 cells. Software-style inspection goes through a registered address/data read port, and a synchronous clear input zeroes the whole grid. A delayed match output models how long the match line takes to settle. The delay is a base latency plus one clock per flipped bit, plus one more clock when the same write also switches display-enable on.

The settle tracker is a three-state machine:
- IDLE: the match output is low.
- SETTLE: the machine counts down the delay.
- MATCHED: the match output is high.

Its transitions are:
- ARM: IDLE to SETTLE on an event.
- RIPEN: SETTLE to MATCHED when the count is spent.
- DROP: SETTLE or MATCHED to IDLE when the stored field no longer equals the raster bits.
- RESTART: SETTLE or MATCHED reloads the count in SETTLE on a fresh event. A fresh event takes priority over DROP.

Top module: `scroll_match_monitor`

## Requirements
- R1: While reset is asserted, and after it is released, the stored scroll field is 0, display-enable is 0, all counters are 0, and `evt_valid`, `evt_den`, `match_dly` and `rd_data` are 0.
- R2: A write (`wr_en`=1) whose new field equals `raster_lo`, while the stored field does not, raises `evt_valid` for exactly one cycle after that clock edge. In that cycle `evt_chan` = old field XOR `raster_lo` (never 0) and `evt_row` = `raster_lo`.
- R3: A write that keeps the field mismatched, leaves it unchanged, or moves it away from a match produces no event and changes no counter. A raster change alone also produces no event.
- R4: `evt_den` is 1 together with `evt_valid` when the triggering write also changes display-enable from 0 to 1. Every write stores `wr_den` as the new display-enable value.
- R5: Each event increments the counter at row `raster_lo`, channel (old XOR `raster_lo`), at the same edge that registers the event.
- R6: Counters are 16 bits wide and hold at 65535 once they reach it.
- R7: `clr`=1 zeroes all 56 counters at the next edge. Clear wins over an event at the same edge.
- R8: `rd_data` returns, one clock after the edge, the counter selected by `rd_row`/`rd_chan` as it was before that edge. `rd_chan`=0 reads 0.
- R9: With base latency B (default 2), `match_dly` rises exactly B + popcount(channel) + (1 if `evt_den`) clocks after the triggering edge, provided the field stays matched.
- R10: `match_dly` drops, and a pending settle is abandoned, at the first edge where the stored field differs from `raster_lo` and no new event occurs. A new event restarts the delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Control register write strobe |
| wr_scroll | input | 3 | Scroll field value being written |
| wr_den | input | 1 | Display-enable value being written |
| raster_lo | input | 3 | Low three bits of the raster line counter |
| clr | input | 1 | Synchronous clear of all counters |
| rd_row | input | 3 | Read row (raster low bits) |
| rd_chan | input | 3 | Read channel, 1 to 7 (0 reads zero) |
| rd_data | output | 16 | Registered counter value |
| evt_valid | output | 1 | One-cycle trigger event pulse |
| evt_chan | output | 3 | Channel of the event |
| evt_row | output | 3 | Raster row of the event |
| evt_den | output | 1 | Event also switched display-enable on |
| match_dly | output | 1 | Settled match indication |

## Verification
The event pulse, the counter increment and the read data all appear one cycle after the edge that sampled the write or the read address. `match_dly` appears B + popcount + display-enable clocks after that edge. The bench drives inputs 2 ns after each rising edge. A behavioural model advances at the same edge, using a cycle number and a due cycle rather than a countdown, and every output is compared at the falling edge that follows. Directed sequences measure the settle delay in whole clocks for one-, two- and three-bit channels with and without display-enable, cover all 56 cells, abort a settle by changing the raster, and drive one cell into saturation. A random phase then mixes writes, raster moves, reads and clears.

// File: rtl/smm_pkg.sv
package smm_pkg;
    localparam int FLD_W = 3;
    localparam int ROWS  = 1 << FLD_W;
    localparam int CHANS = ROWS - 1;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SETTLE  = 2'd1,
        ST_MATCHED = 2'd2
    } settle_st_t;

    function automatic logic [1:0] flip_count(input logic [FLD_W-1:0] v);
        logic [1:0] n;
        n = '0;
        for (int i = 0; i < FLD_W; i++) begin
            n = n + 2'(v[i]);
        end
        return n;
    endfunction
endpackage

// File: rtl/smm_detect.sv
module smm_detect
    import smm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [FLD_W-1:0] wr_scroll,
    input  logic             wr_den,
    input  logic [FLD_W-1:0] raster_lo,
    output logic             trig,
    output logic [FLD_W-1:0] trig_chan,
    output logic             trig_den,
    output logic             live_eq,
    output logic             evt_valid,
    output logic [FLD_W-1:0] evt_chan,
    output logic [FLD_W-1:0] evt_row,
    output logic             evt_den
);
    logic [FLD_W-1:0] scroll_q;
    logic             den_q;
    logic             new_eq;

    // bitwise compare folded into a single all-zero test
    assign live_eq   = ~|(scroll_q ^ raster_lo);
    assign new_eq    = ~|(wr_scroll ^ raster_lo);
    assign trig      = wr_en & ~live_eq & new_eq;
    assign trig_chan = scroll_q ^ raster_lo;
    assign trig_den  = wr_en & wr_den & ~den_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scroll_q <= '0;
            den_q    <= 1'b0;
        end else if (wr_en) begin
            scroll_q <= wr_scroll;
            den_q    <= wr_den;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            evt_valid <= 1'b0;
            evt_chan  <= '0;
            evt_row   <= '0;
            evt_den   <= 1'b0;
        end else begin
            evt_valid <= trig;
            evt_chan  <= trig ? trig_chan : '0;
            evt_row   <= trig ? raster_lo : '0;
            evt_den   <= trig & trig_den;
        end
    end

    // R2
    evt_chan_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid |-> (evt_chan != '0));

    // R3
    no_evt_same_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_scroll == scroll_q) |=> !evt_valid);

    // R4
    den_with_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_den |-> evt_valid);
endmodule

// File: rtl/smm_grid.sv
module smm_grid
    import smm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    input  logic [FLD_W-1:0] inc_row,
    input  logic [FLD_W-1:0] inc_chan,
    input  logic [FLD_W-1:0] rd_row,
    input  logic [FLD_W-1:0] rd_chan,
    output logic [CNT_W-1:0] rd_data
);
    localparam int CELLS = ROWS * CHANS;
    localparam int IDX_W = $clog2(CELLS);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q [CELLS];
    logic [IDX_W-1:0] rd_idx;

    assign rd_idx = IDX_W'(rd_row) * IDX_W'(CHANS) + IDX_W'(rd_chan) - IDX_W'(1);

    for (genvar g = 0; g < CELLS; g++) begin : g_cell
        localparam int ROW_I = g / CHANS;
        localparam int COL_I = (g % CHANS) + 1;
        logic hit;

        assign hit = inc && (inc_row == FLD_W'(ROW_I)) && (inc_chan == FLD_W'(COL_I));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cnt_q[g] <= '0;
            end else if (clr) begin
                cnt_q[g] <= '0;
            end else if (hit && cnt_q[g] != CNT_MAX) begin
                cnt_q[g] <= cnt_q[g] + CNT_W'(1);
            end
        end

        // R6
        sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt_q[g] == CNT_MAX && !clr) |=> (cnt_q[g] == CNT_MAX));

        // R7
        clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            clr |=> (cnt_q[g] == '0));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_chan == '0) begin
            rd_data <= '0;
        end else begin
            rd_data <= cnt_q[rd_idx];
        end
    end
endmodule

// File: rtl/smm_settle.sv
module smm_settle
    import smm_pkg::*;
#(
    parameter int BASE_LAT = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig,
    input  logic [FLD_W-1:0] trig_chan,
    input  logic             trig_den,
    input  logic             live_eq,
    output logic             match_dly
);
    localparam int MAX_DLY = BASE_LAT + FLD_W + 1;
    localparam int DLY_W   = $clog2(MAX_DLY + 1);

    settle_st_t       st_q, st_d;
    logic [DLY_W-1:0] rem_q, rem_d;
    logic [DLY_W-1:0] load_val;

    assign load_val = DLY_W'(BASE_LAT) + DLY_W'(flip_count(trig_chan))
                    + DLY_W'(trig_den) - DLY_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            rem_q <= '0;
        end else begin
            st_q  <= st_d;
            rem_q <= rem_d;
        end
    end

    always_comb begin
        st_d  = st_q;
        rem_d = rem_q;
        unique case (st_q)
            ST_IDLE: begin
                if (trig) begin            // ARM
                    st_d  = ST_SETTLE;
                    rem_d = load_val;
                end
            end
            ST_SETTLE: begin
                if (trig) begin            // RESTART
                    rem_d = load_val;
                end else if (!live_eq) begin   // DROP
                    st_d = ST_IDLE;
                end else if (rem_q == '0) begin   // RIPEN
                    st_d = ST_MATCHED;
                end else begin
                    rem_d = rem_q - DLY_W'(1);
                end
            end
            ST_MATCHED: begin
                if (trig) begin            // RESTART
                    st_d  = ST_SETTLE;
                    rem_d = load_val;
                end else if (!live_eq) begin   // DROP
                    st_d = ST_IDLE;
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_comb begin
        match_dly = (st_q == ST_MATCHED);
    end

    // R10
    matched_needs_eq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_MATCHED) |-> $past(live_eq));

    // R9
    rise_after_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(match_dly) |-> ($past(st_q) == ST_SETTLE && $past(rem_q) == '0));
endmodule

// File: rtl/scroll_match_monitor.sv
module scroll_match_monitor
    import smm_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int BASE_LAT = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [2:0]       wr_scroll,
    input  logic             wr_den,
    input  logic [2:0]       raster_lo,
    input  logic             clr,
    input  logic [2:0]       rd_row,
    input  logic [2:0]       rd_chan,
    output logic [CNT_W-1:0] rd_data,
    output logic             evt_valid,
    output logic [2:0]       evt_chan,
    output logic [2:0]       evt_row,
    output logic             evt_den,
    output logic             match_dly
);
    logic             trig;
    logic [FLD_W-1:0] trig_chan;
    logic             trig_den;
    logic             live_eq;

    smm_detect i_detect (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_scroll (wr_scroll),
        .wr_den    (wr_den),
        .raster_lo (raster_lo),
        .trig      (trig),
        .trig_chan (trig_chan),
        .trig_den  (trig_den),
        .live_eq   (live_eq),
        .evt_valid (evt_valid),
        .evt_chan  (evt_chan),
        .evt_row   (evt_row),
        .evt_den   (evt_den)
    );

    smm_grid #(.CNT_W(CNT_W)) i_grid (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .inc      (trig),
        .inc_row  (raster_lo),
        .inc_chan (trig_chan),
        .rd_row   (rd_row),
        .rd_chan  (rd_chan),
        .rd_data  (rd_data)
    );

    smm_settle #(.BASE_LAT(BASE_LAT)) i_settle (
        .clk       (clk),
        .rst_n     (rst_n),
        .trig      (trig),
        .trig_chan (trig_chan),
        .trig_den  (trig_den),
        .live_eq   (live_eq),
        .match_dly (match_dly)
    );

    // R5
    evt_row_tracks_raster_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> (evt_valid && evt_row == $past(raster_lo)));
endmodule

// File: tb/test_scroll_match_monitor.sv
module test_scroll_match_monitor;
    localparam int BASE = 2;
    localparam int SATV = 65535;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_scroll = '0;
    logic        wr_den = 1'b0;
    logic [2:0]  raster_lo = '0;
    logic        clr = 1'b0;
    logic [2:0]  rd_row = '0;
    logic [2:0]  rd_chan = '0;
    logic [15:0] rd_data;
    logic        evt_valid;
    logic [2:0]  evt_chan;
    logic [2:0]  evt_row;
    logic        evt_den;
    logic        match_dly;

    always #4 clk = ~clk;

    scroll_match_monitor #(.CNT_W(16), .BASE_LAT(BASE)) i_scroll_match_monitor (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_scroll(wr_scroll),
        .wr_den(wr_den), .raster_lo(raster_lo), .clr(clr), .rd_row(rd_row),
        .rd_chan(rd_chan), .rd_data(rd_data), .evt_valid(evt_valid),
        .evt_chan(evt_chan), .evt_row(evt_row), .evt_den(evt_den),
        .match_dly(match_dly)
    );

    int total = 0;
    int bad = 0;
    bit done = 0;

    task automatic check(input string tag, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // behavioural reference model
    int m_cnt [56];
    int m_scroll, m_den, k, due;
    bit armed;
    int e_rd, e_chan, e_row;
    bit e_evt, e_den, e_match;

    function automatic int ones(input int v);
        int n = 0;
        for (int b = 0; b < 3; b++) if (v[b]) n++;
        return n;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 56; i++) m_cnt[i] = 0;
            m_scroll = 0; m_den = 0; k = 0; due = 0; armed = 0;
            e_rd = 0; e_chan = 0; e_row = 0; e_evt = 0; e_den = 0; e_match = 0;
        end else begin
            bit t;
            int ch;
            k++;
            ch = m_scroll ^ int'(raster_lo);
            t = wr_en && (m_scroll != int'(raster_lo)) && (int'(wr_scroll) == int'(raster_lo));
            e_rd = (rd_chan == 0) ? 0 : m_cnt[int'(rd_row) * 7 + int'(rd_chan) - 1];
            e_evt = t; e_chan = ch; e_row = raster_lo;
            e_den = t && wr_den && (m_den == 0);
            if (t) begin
                armed = 1;
                due = k + BASE + ones(ch) + (e_den ? 1 : 0);
            end else if (armed && m_scroll != int'(raster_lo)) begin
                armed = 0;
            end
            if (clr) begin
                for (int i = 0; i < 56; i++) m_cnt[i] = 0;
            end else if (t && m_cnt[int'(raster_lo) * 7 + ch - 1] < SATV) begin
                m_cnt[int'(raster_lo) * 7 + ch - 1]++;
            end
            if (wr_en) begin
                m_scroll = wr_scroll;
                m_den = wr_den;
            end
            e_match = armed && (k >= due);
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            check("R2", "evt_valid", evt_valid, e_evt);
            if (e_evt) begin
                check("R2", "evt_chan", evt_chan, e_chan);
                check("R5", "evt_row", evt_row, e_row);
            end
            check("R4", "evt_den", evt_den, e_den);
            check("R9", "match_dly", match_dly, e_match);
            check("R8", "rd_data", rd_data, e_rd);
        end
    end

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #2;
        end
    endtask

    task automatic wr(input int s, input bit d);
        @(posedge clk); #2;
        wr_en = 1'b1; wr_scroll = 3'(s); wr_den = d;
        @(posedge clk); #2;
        wr_en = 1'b0;
    endtask

    task automatic measure(input string tag, input int exp);
        int n = 0;
        bit seen = 0;
        for (int i = 1; i <= 10; i++) begin
            @(posedge clk); #2;
            if (match_dly && !seen) begin n = i; seen = 1; end
        end
        check(tag, "settle clocks", n, exp);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        // R1: reset state
        step(3);
        #2;
        check("R1", "match during reset", match_dly, 0);
        check("R1", "rd during reset", rd_data, 0);
        @(posedge clk); #1; rst_n = 1'b1; #1;
        rd_row = 3'd5; rd_chan = 3'd3;
        step(2);
        check("R1", "cell read after reset", rd_data, 0);

        // R9: delay for 3, 2 and 1 flipped bits, with and without display-enable rise
        raster_lo = 3'd0;
        wr(7, 1); step(2);
        wr(0, 1); measure("R9", BASE + 3);
        wr(4, 0); step(2);
        wr(0, 1); measure("R9", BASE + 2);
        wr(6, 1); step(2);
        wr(0, 1); measure("R9", BASE + 2);
        raster_lo = 3'd5;
        wr(5, 1); step(1);
        wr(6, 1); step(2);
        wr(5, 1); measure("R9", BASE + 2);

        // all 56 cells, one event each after clearing
        @(posedge clk); #2; clr = 1'b1; @(posedge clk); #2; clr = 1'b0;
        for (int r = 0; r < 8; r++) begin
            raster_lo = 3'(r);
            for (int o = 0; o < 8; o++) begin
                if (o != r) begin
                    wr(o, o[0]); step(1);
                    wr(r, 1'b1); step(6);
                end
            end
        end
        for (int r = 0; r < 8; r++) begin
            for (int c = 1; c < 8; c++) begin
                rd_row = 3'(r); rd_chan = 3'(c);
                step(1);
                check("R5", "cell after sweep", rd_data, 1);
            end
        end
        rd_chan = 3'd0; step(1);
        check("R8", "channel 0 reads zero", rd_data, 0);

        // R3: writes that keep a mismatch, repeat a value, or leave a match
        raster_lo = 3'd2; rd_row = 3'd2; rd_chan = 3'd1;
        wr(3, 1); step(1);
        wr(7, 1); step(1);
        wr(7, 1); step(1);
        raster_lo = 3'd7; step(2);
        wr(7, 1); step(1);
        wr(1, 1); step(2);
        check("R3", "cell unchanged", rd_data, 1);

        // R10: raster moves during settle, then a restart
        raster_lo = 3'd1;
        wr(6, 1); step(1);
        wr(1, 1); step(1);
        raster_lo = 3'd3; step(3);
        check("R10", "dropped after raster move", match_dly, 0);
        wr(1, 1); step(1);
        raster_lo = 3'd1;
        wr(1, 1); step(1);
        wr(2, 1); step(1);
        wr(1, 1); measure("R10", BASE + 2);

        // R7: clear together with an event
        raster_lo = 3'd4; rd_row = 3'd4; rd_chan = 3'd4;
        wr(0, 1); step(1);
        @(posedge clk); #2;
        wr_en = 1'b1; wr_scroll = 3'd4; clr = 1'b1;
        @(posedge clk); #2;
        wr_en = 1'b0; clr = 1'b0;
        step(2);
        check("R7", "clear wins over event", rd_data, 0);

        // random mix
        for (int i = 0; i < 3000; i++) begin
            @(posedge clk); #2;
            wr_en = ($urandom % 3) == 0;
            wr_scroll = 3'($urandom);
            wr_den = 1'($urandom);
            if (($urandom % 8) == 0) raster_lo = 3'($urandom);
            clr = ($urandom % 200) == 0;
            rd_row = 3'($urandom);
            rd_chan = 3'($urandom);
        end
        @(posedge clk); #2; wr_en = 1'b0; clr = 1'b0;

        // R6: saturation of one cell
        raster_lo = 3'd0; rd_row = 3'd0; rd_chan = 3'd1;
        wr(0, 1);
        @(posedge clk); #2; clr = 1'b1; @(posedge clk); #2; clr = 1'b0;
        for (int j = 0; j < 131082; j++) begin
            wr_en = 1'b1;
            wr_scroll = (j % 2 == 0) ? 3'd1 : 3'd0;
            @(posedge clk); #2;
        end
        wr_en = 1'b0;
        step(2);
        check("R6", "saturated cell", rd_data, SATV);

        finish_run();
    end
endmodule